// File: doc/BRIEF.md
# Resume Power Sequencer

This block brings a system out of a powered-on-suspend state and back to full operation. It runs on the system clock. All of its delays are counted in a slow timing tick of about 32 µs, which arrives as a one-cycle enable pulse on `rtc_tick`. When a resume event arrives, the block releases its outputs in a fixed order: first the suspend, sleep and stop-clock controls; then both clock-stop lines, once the clock synthesizer has had time to lock and power is good; then the suspend status pair; then the PCI reset; and last the CPU reset.

Every output is active-low, and a low level means the control is asserted. The power-good input may be asynchronous, so the block passes it through a synchronizer before using it. Once the sequence is complete, `seq_done` goes high. From then on the clock-stop lines follow an external request. A go-to-suspend request returns the block to the suspended state, and only from that state can a new resume start the sequence again.

Top module: `resume_pwr_seq`

## Requirements
- R1: After reset the block is suspended. Every active-low output (`sus_ctl_n`, `slp_n`, `stpclk_n`, `pci_rst_n`, `cpu_rst_n`, `pci_stp_n`, `cpu_stp_n`, both bits of `sus_stat_n`) is 0, and `seq_done` is 0.
- R2: A one-cycle `resume_evt` pulse seen while suspended takes effect at the first `rtc_tick` at or after it. A pulse in the same cycle as a tick counts as that tick. At that tick `sus_ctl_n`, `slp_n` and `stpclk_n` rise to 1, while both resets stay at 0.
- R3: `pci_stp_n` and `cpu_stp_n` rise together, at the first tick t that meets three conditions. First, t is at least LOCK_TICKS ticks after the R2 tick. Second, synchronized power-good was high at tick t. Third, it was also high at the tick before t. Power-good passes through SYNC_STAGES flip-flops.
- R4: If power-good rises late, the clock-stop release comes at the second tick at which the synchronized power-good is seen high, and never earlier.
- R5: Both bits of `sus_stat_n` rise to 1 exactly STAT_TICKS ticks after the clock-stop release.
- R6: `pci_rst_n` rises to 1 one tick after the suspend status pair goes inactive.
- R7: One tick after `pci_rst_n` rises, `cpu_rst_n` and `seq_done` rise to 1. From then on, `pci_stp_n` and `cpu_stp_n` both equal the inverse of `clk_stop_req`.
- R8: `clk_stop_req` has no effect on any output before `seq_done` is 1.
- R9: `resume_evt` is ignored in every state other than suspended.
- R10: `suspend_req`, seen in any state other than suspended, returns the block to the suspended state (the R1 outputs) at that clock edge. This holds even when a tick would have advanced the sequence in the same cycle.
- R11: `suspend_req` has no effect while the block is suspended. A `resume_evt` in the same cycle still starts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | One-cycle enable, one per slow-tick period |
| resume_evt | input | 1 | Wake request pulse |
| pwr_good | input | 1 | Power-good level, asynchronous |
| suspend_req | input | 1 | Return to the suspended state |
| clk_stop_req | input | 1 | Clock-stop request, honoured after the sequence completes |
| sus_ctl_n | output | 1 | Suspend control, active-low |
| slp_n | output | 1 | Sleep, active-low |
| stpclk_n | output | 1 | Stop-clock, active-low |
| pci_rst_n | output | 1 | PCI reset, active-low |
| cpu_rst_n | output | 1 | CPU reset, active-low |
| pci_stp_n | output | 1 | PCI clock stop, active-low |
| cpu_stp_n | output | 1 | CPU clock stop, active-low |
| sus_stat_n | output | 2 | Suspend status pair, active-low |
| seq_done | output | 1 | Wake sequence complete |

## Verification
Two functions can fall in the same cycle: the tick that moves the sequence forward and a go-to-suspend request. The bench raises `suspend_req` in the very cycle of a tick at every step of the sequence, including the final tick that would release the CPU reset. It expects the suspended outputs at each step and no trace of the advance. It also pairs a resume pulse with a tick, and a resume with a suspend request while suspended, and judges the result by the tick index at which the first release is seen.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_SUSP,
        ST_WAKE,
        ST_LOCK,
        ST_STAT,
        ST_PRST,
        ST_CRST,
        ST_RUN
    } seq_state_e;

endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
    import pwr_seq_pkg::*;
#(
    parameter int LOCK_TICKS = 500,
    parameter int STAT_TICKS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rtc_tick,
    input  logic       resume_evt,
    input  logic       pg_s,
    input  logic       suspend_req,
    output seq_state_e state
);

    localparam int MAX_T = (LOCK_TICKS > STAT_TICKS) ? LOCK_TICKS : STAT_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_TICKS - 1);
    localparam logic [CNT_W-1:0] STAT_LAST = CNT_W'(STAT_TICKS - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             pg_ok;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rtc_tick) r_d.pg_ok = pg_s;
        unique case (r_q.state)
            ST_SUSP: begin
                if (resume_evt) begin
                    r_d.cnt   = '0;
                    r_d.state = rtc_tick ? ST_LOCK : ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (rtc_tick) begin
                    r_d.cnt   = '0;
                    r_d.state = ST_LOCK;
                end
            end
            ST_LOCK: begin
                if (rtc_tick) begin
                    if (r_q.cnt == LOCK_LAST && r_q.pg_ok && pg_s) begin
                        r_d.cnt   = '0;
                        r_d.state = ST_STAT;
                    end else if (r_q.cnt != LOCK_LAST) begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_STAT: begin
                if (rtc_tick) begin
                    if (r_q.cnt == STAT_LAST) r_d.state = ST_PRST;
                    else                      r_d.cnt   = r_q.cnt + CNT_W'(1);
                end
            end
            ST_PRST: if (rtc_tick) r_d.state = ST_CRST;
            ST_CRST: if (rtc_tick) r_d.state = ST_RUN;
            ST_RUN:  ;
            default: r_d.state = ST_SUSP;
        endcase
        if (suspend_req && r_q.state != ST_SUSP) begin
            r_d.state = ST_SUSP;
            r_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_SUSP;
            r_q.cnt   <= '0;
            r_q.pg_ok <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.state;

    // Clock-stop release only after power-good was seen at two ticks in a row
    assert_release_pg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_STAT && $past(r_q.state) == ST_LOCK) |-> ($past(pg_s) && $past(r_q.pg_ok)));

    // Outside suspend, the state moves only on a tick or a suspend request
    assert_tick_paced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_SUSP && !rtc_tick && !suspend_req) |=> $stable(r_q.state));

    assert_resume_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && resume_evt && !suspend_req) |=> r_q.state == ST_RUN);

    assert_suspend_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend_req && r_q.state != ST_SUSP) |=> r_q.state == ST_SUSP);

    initial begin
        assert_params_R3: assert (LOCK_TICKS >= 2 && STAT_TICKS >= 1);
    end

endmodule

// File: rtl/pin_decode.sv
module pin_decode
    import pwr_seq_pkg::*;
(
    input  seq_state_e state,
    input  logic       clk_stop_req,
    output logic       sus_ctl_n,
    output logic       slp_n,
    output logic       stpclk_n,
    output logic       pci_rst_n,
    output logic       cpu_rst_n,
    output logic       pci_stp_n,
    output logic       cpu_stp_n,
    output logic [1:0] sus_stat_n,
    output logic       seq_done
);

    logic awake, clk_rel, stat_rel, pci_rel, run;

    always_comb begin
        awake    = !(state inside {ST_SUSP, ST_WAKE});
        clk_rel  = state inside {ST_STAT, ST_PRST, ST_CRST, ST_RUN};
        stat_rel = state inside {ST_PRST, ST_CRST, ST_RUN};
        pci_rel  = state inside {ST_CRST, ST_RUN};
        run      = (state == ST_RUN);

        sus_ctl_n  = awake;
        slp_n      = awake;
        stpclk_n   = awake;
        pci_stp_n  = run ? ~clk_stop_req : clk_rel;
        cpu_stp_n  = run ? ~clk_stop_req : clk_rel;
        sus_stat_n = {2{stat_rel}};
        pci_rst_n  = pci_rel;
        cpu_rst_n  = run;
        seq_done   = run;
    end

endmodule

// File: rtl/resume_pwr_seq.sv
module resume_pwr_seq
    import pwr_seq_pkg::*;
#(
    parameter int LOCK_TICKS  = 500,
    parameter int STAT_TICKS  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rtc_tick,
    input  logic       resume_evt,
    input  logic       pwr_good,
    input  logic       suspend_req,
    input  logic       clk_stop_req,
    output logic       sus_ctl_n,
    output logic       slp_n,
    output logic       stpclk_n,
    output logic       pci_rst_n,
    output logic       cpu_rst_n,
    output logic       pci_stp_n,
    output logic       cpu_stp_n,
    output logic [1:0] sus_stat_n,
    output logic       seq_done
);

    logic       pg_s;
    seq_state_e state;

    pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pwr_good),
        .dout (pg_s)
    );

    wake_fsm #(.LOCK_TICKS(LOCK_TICKS), .STAT_TICKS(STAT_TICKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rtc_tick   (rtc_tick),
        .resume_evt (resume_evt),
        .pg_s       (pg_s),
        .suspend_req(suspend_req),
        .state      (state)
    );

    pin_decode u_dec (
        .state       (state),
        .clk_stop_req(clk_stop_req),
        .sus_ctl_n   (sus_ctl_n),
        .slp_n       (slp_n),
        .stpclk_n    (stpclk_n),
        .pci_rst_n   (pci_rst_n),
        .cpu_rst_n   (cpu_rst_n),
        .pci_stp_n   (pci_stp_n),
        .cpu_stp_n   (cpu_stp_n),
        .sus_stat_n  (sus_stat_n),
        .seq_done    (seq_done)
    );

    assert_cpu_after_pci_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_n) |-> $past(pci_rst_n));

    assert_stat_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sus_stat_n[0]) |-> ($past(pci_stp_n) && $past(cpu_stp_n)));

    assert_pci_after_stat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_rst_n) |-> ($past(sus_stat_n) == 2'b11));

endmodule

// File: tb/tb_resume_pwr_seq.sv
`timescale 1ns/1ps
module tb_resume_pwr_seq;

    localparam int LT = 6;
    localparam int ST = 3;

    logic clk = 1'b0, rst_n = 1'b0, rtc_tick = 1'b0, resume_evt = 1'b0;
    logic pwr_good = 1'b0, suspend_req = 1'b0, clk_stop_req = 1'b0;
    logic sus_ctl_n, slp_n, stpclk_n, pci_rst_n, cpu_rst_n, pci_stp_n, cpu_stp_n, seq_done;
    logic [1:0] sus_stat_n;

    int n = 0, tests = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    resume_pwr_seq #(.LOCK_TICKS(LT), .STAT_TICKS(ST), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .resume_evt(resume_evt),
        .pwr_good(pwr_good), .suspend_req(suspend_req), .clk_stop_req(clk_stop_req),
        .sus_ctl_n(sus_ctl_n), .slp_n(slp_n), .stpclk_n(stpclk_n), .pci_rst_n(pci_rst_n),
        .cpu_rst_n(cpu_rst_n), .pci_stp_n(pci_stp_n), .cpu_stp_n(cpu_stp_n),
        .sus_stat_n(sus_stat_n), .seq_done(seq_done)
    );

    // bits: sus, slp, stpclk, pci_rst, cpu_rst, pci_stp, cpu_stp, stat[1:0], done
    function automatic logic [9:0] exp_pins(int ph, logic req);
        case (ph)
            0: return 10'b000_00_00_00_0;
            1: return 10'b111_00_00_00_0;
            2: return 10'b111_00_11_00_0;
            3: return 10'b111_00_11_11_0;
            4: return 10'b111_10_11_11_0;
            default: return {3'b111, 2'b11, ~req, ~req, 2'b11, 1'b1};
        endcase
    endfunction

    function automatic int phase_of(int i, int w, int r);
        if (i < w)          return 0;
        if (i < r)          return 1;
        if (i < r + ST)     return 2;
        if (i == r + ST)    return 3;
        if (i == r + ST + 1) return 4;
        return 5;
    endfunction

    task automatic check(int ph, string tag);
        logic [9:0] act;
        logic [9:0] ex;
        act = {sus_ctl_n, slp_n, stpclk_n, pci_rst_n, cpu_rst_n, pci_stp_n, cpu_stp_n, sus_stat_n, seq_done};
        ex  = exp_pins(ph, clk_stop_req);
        tests++;
        if (act !== ex) begin
            fails++;
            $display("FAIL %s: pins actual=%b expected=%b (tick %0d)", tag, act, ex, n);
        end
    endtask

    task automatic step(bit res, bit coinc, bit sus);
        @(negedge clk) resume_evt = res && !coinc;
        @(negedge clk) resume_evt = 1'b0;
        @(negedge clk);
        @(negedge clk) begin
            rtc_tick = 1'b1;
            resume_evt = res && coinc;
            suspend_req = sus;
        end
        @(negedge clk) begin
            rtc_tick = 1'b0;
            resume_evt = 1'b0;
            suspend_req = 1'b0;
        end
        n++;
    endtask

    task automatic do_reset(bit pg0);
        rst_n = 1'b0;
        rtc_tick = 1'b0; resume_evt = 1'b0; suspend_req = 1'b0; clk_stop_req = 1'b0;
        pwr_good = pg0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        check(0, "R1");
    endtask

    // w: tick index of resume, k: pg goes high after tick k (k<0: high from reset)
    task automatic run_seq(int w, bit coinc, int k, bit req, int abort_at);
        int r, endn, ph;
        string tag;
        bit stop;
        do_reset(k < 0);
        clk_stop_req = req;
        r = (w + LT > k + 2) ? w + LT : k + 2;
        endn = r + ST + 2;
        stop = 0;
        for (int i = 1; i <= endn && !stop; i++) begin
            step(i == w || i == w + 1, coinc && i == w, i == abort_at);
            if (i == k) pwr_good = 1'b1;
            if (i == abort_at) begin
                check(0, "R10");
                stop = 1;
            end else begin
                ph = phase_of(i, w, r);
                if (i == w + 1)                           tag = "R9";
                else if (ph == 0)                         tag = "R1";
                else if (ph == 1 && i == w)               tag = "R2";
                else if (ph <= 2 && k + 2 > w + LT)       tag = "R4";
                else if (ph <= 2)                         tag = "R3";
                else if (ph == 3)                         tag = "R5";
                else if (ph == 4)                         tag = req ? "R8" : "R6";
                else                                      tag = "R7";
                check(ph, tag);
            end
        end
        if (abort_at == 0) begin
            @(negedge clk) clk_stop_req = ~req;
            @(negedge clk) check(5, "R7");
            @(negedge clk) resume_evt = 1'b1;
            @(negedge clk) resume_evt = 1'b0;
            step(0, 0, 0);
            check(5, "R9");
            @(negedge clk) suspend_req = 1'b1;
            @(negedge clk) suspend_req = 1'b0;
            clk_stop_req = 1'b0;
            check(0, "R10");
            @(negedge clk) begin suspend_req = 1'b1; resume_evt = 1'b1; end
            @(negedge clk) begin suspend_req = 1'b0; resume_evt = 1'b0; end
            check(0, "R11");
            step(0, 0, 0);
            check(1, "R11");
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        for (int w = 1; w <= 2; w++)
            for (int c = 0; c < 2; c++)
                for (int k = -1; k <= w + LT + 2; k++)
                    if (k != 0) run_seq(w, c[0], k, k[0], 0);
        // suspend request at every step, including the tick that would finish the sequence
        for (int a = 3; a <= 2 + LT + ST + 2; a++) run_seq(2, 0, -1, 1'b0, a);
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R1: watchdog actual=hung expected=finished");
        report();
    end

endmodule